// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the effective address of a single-register memory access and shapes the data that moves with it. For each request it combines a base value with either an immediate or a shifted register offset, adds or subtracts that offset, and uses the result either as the access address (pre-indexed) or only as the new base (post-indexed). Any new base value is presented on a separate writeback output. A base that comes from the program counter is first rounded down to a multiple of 4.

On the bus side it gives the access address, the byte enables of a little-endian 32-bit bus, and store data copied onto every lane. When the bus returns the word for a load, the unit selects and zero-extends a byte or halfword, or, for a misaligned word with unaligned access disabled, rotates the word so that the addressed byte lands in the lowest lane. A word load into register 15 is marked as a program-counter load when it is word aligned. Otherwise it raises an unpredictable flag. A halfword at an odd address with unaligned access disabled raises an unknown-result flag.

Request outputs are registered and appear one cycle after the request. Load results are registered and appear one cycle after the returned word. The bus itself is outside the block.

Top module: `ls_addr_unit`

## Requirements
- R1: The offset address is the effective base plus the offset when req_add is 1, and the effective base minus the offset when req_add is 0 (modulo 2^32).
- R2: The access address acc_addr is the offset address when req_pre is 1, and the effective base when req_pre is 0.
- R3: wb_valid equals req_wb of the request, and wb_value carries the offset address.
- R4: When req_base_pc is 1, the effective base is req_base with bits [1:0] cleared. Otherwise it is req_base unchanged.
- R5: When req_imm_sel is 1, the offset is req_imm. Otherwise it is req_oreg shifted by req_sh_amt (0..31, where 0 leaves the value unchanged). The shift kind is set by req_sh_kind: 0 is a logical left shift, 1 a logical right shift, 2 an arithmetic right shift and 3 a rotate right.
- R6: The size is coded in req_size as 0 for byte, 1 for halfword and 2 for word. acc_be is 1 shifted left by addr[1:0] for a byte access, 4'b0011 for a halfword with addr[1]=0, 4'b1100 for a halfword with addr[1]=1, and 4'b1111 for a word.
- R7: acc_wdata holds req_src[7:0] copied into all four bytes for a byte access, req_src[15:0] copied into both halves for a halfword, and req_src for a word. acc_write is the inverse of req_load.
- R8: Byte loads return byte addr[1:0] of ld_word, zero-extended. Halfword loads return the half of ld_word selected by addr[1], zero-extended.
- R9: A word load returns ld_word rotated right by 8*addr[1:0] when addr[1:0] is nonzero and req_unaligned_ok is 0. In every other case it returns ld_word unchanged.
- R10: A word load with req_tgt = 15 sets res_pc with its result when addr[1:0] = 0. When addr[1:0] is nonzero it sets flag_unpred instead, and res_pc stays 0.
- R11: flag_unknown is 1 exactly for a halfword access with addr[0] = 1 and req_unaligned_ok = 0.
- R12: After reset all outputs are 0. acc_valid pulses for one cycle, one cycle after req_valid. res_valid pulses for one cycle, one cycle after ld_valid. The other access outputs hold until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_load | input | 1 | 1 = load, 0 = store |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_base | input | 32 | Base register value |
| req_base_pc | input | 1 | Base is the program counter (round down to 4) |
| req_imm_sel | input | 1 | Use the immediate offset |
| req_imm | input | 32 | Immediate offset |
| req_oreg | input | 32 | Offset register value |
| req_sh_kind | input | 2 | Shift kind for the register offset |
| req_sh_amt | input | 5 | Shift amount for the register offset |
| req_add | input | 1 | 1 = add offset, 0 = subtract |
| req_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| req_wb | input | 1 | Write the offset address back to the base |
| req_tgt | input | 4 | Target register index |
| req_unaligned_ok | input | 1 | Unaligned access supported |
| req_src | input | 32 | Store source value |
| ld_valid | input | 1 | Load word returned by the bus |
| ld_word | input | 32 | Returned load word |
| acc_valid | output | 1 | Access outputs updated (one-cycle pulse) |
| acc_write | output | 1 | Access is a store |
| acc_addr | output | 32 | Access address |
| acc_be | output | 4 | Byte enables |
| acc_wdata | output | 32 | Lane-replicated store data |
| wb_valid | output | 1 | Base writeback requested |
| wb_value | output | 32 | New base value |
| flag_unpred | output | 1 | Misaligned word load to register 15 |
| flag_unknown | output | 1 | Misaligned halfword without unaligned support |
| res_valid | output | 1 | Load result valid (one-cycle pulse) |
| res_data | output | 32 | Adjusted load result |
| res_pc | output | 1 | Load result goes to the program counter |

## Verification
The address path is driven with immediate offsets in pre- and post-indexed, add and subtract combinations. These tell apart the index choice, the sign of the offset and the writeback value. A fixed register value is then shifted by each of the four shift kinds and by zero, with a top bit set so that logical and arithmetic right shifts give different results. Each of the byte, halfword and word loads is tried at aligned and misaligned addresses, with unaligned support on and off and with a target of register 15. This separates lane selection, rotation, the program-counter marking and the two flags. A base flagged as the program counter with nonzero low bits shows whether the rounding happens before the offset is applied.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/agu_offset.sv
module agu_offset
    import agu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] base,
    input  logic            base_pc,
    input  logic            imm_sel,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] oreg,
    input  logic [1:0]      sh_kind,
    input  logic [SHW-1:0]  sh_amt,
    input  logic            add,
    input  logic            pre,
    output logic [XLEN-1:0] off_addr,
    output logic [XLEN-1:0] acc_addr
);

    logic [XLEN-1:0]   base_eff;
    logic [XLEN-1:0]   shifted;
    logic [XLEN-1:0]   offset;
    logic [2*XLEN-1:0] rot_dbl;

    always_comb begin
        // program-counter bases are rounded down to a multiple of 4 (R4)
        base_eff = base_pc ? {base[XLEN-1:2], 2'b00} : base;
        rot_dbl  = {oreg, oreg} >> sh_amt;
        unique case (shift_kind_e'(sh_kind))
            SH_LSL:  shifted = oreg << sh_amt;
            SH_LSR:  shifted = oreg >> sh_amt;
            SH_ASR:  shifted = $signed(oreg) >>> sh_amt;
            default: shifted = rot_dbl[XLEN-1:0];
        endcase
        offset   = imm_sel ? imm : shifted;
        off_addr = add ? (base_eff + offset) : (base_eff - offset);
        acc_addr = pre ? off_addr : base_eff;
    end

endmodule

// File: rtl/agu_lanes.sv
module agu_lanes
    import agu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NB    = XLEN / 8,
    localparam int LOW_W = $clog2(NB)
) (
    input  logic [LOW_W-1:0] lo,
    input  logic [1:0]       size,
    input  logic [XLEN-1:0]  src,
    output logic [NB-1:0]    be,
    output logic [XLEN-1:0]  wdata
);

    logic [LOW_W-1:0] half_lo;

    always_comb begin
        half_lo = {lo[LOW_W-1:1], 1'b0};
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                be    = NB'(1) << lo;
                wdata = {NB{src[7:0]}};
            end
            SZ_HALF: begin
                be    = NB'(3) << half_lo;
                wdata = {(NB/2){src[15:0]}};
            end
            default: begin
                be    = '1;
                wdata = src;
            end
        endcase
    end

endmodule

// File: rtl/agu_ldfmt.sv
module agu_ldfmt
    import agu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NB    = XLEN / 8,
    localparam int LOW_W = $clog2(NB)
) (
    input  logic [XLEN-1:0]  word,
    input  logic [LOW_W-1:0] lo,
    input  logic [1:0]       size,
    input  logic             unaligned_ok,
    output logic [XLEN-1:0]  data
);

    logic [XLEN-1:0]   byte_sh;
    logic [XLEN-1:0]   half_sh;
    logic [2*XLEN-1:0] rot_dbl;

    always_comb begin
        byte_sh = word >> {lo, 3'b000};
        half_sh = word >> {lo[LOW_W-1:1], 4'b0000};
        rot_dbl = {word, word} >> {lo, 3'b000};
        unique case (acc_size_e'(size))
            SZ_BYTE: data = {{(XLEN-8){1'b0}}, byte_sh[7:0]};
            SZ_HALF: data = {{(XLEN-16){1'b0}}, half_sh[15:0]};
            default: data = (lo != '0 && !unaligned_ok) ? rot_dbl[XLEN-1:0] : word;
        endcase
    end

endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
    import agu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_W  = 4,
    parameter int PC_IDX = 15,
    localparam int NB    = XLEN / 8,
    localparam int LOW_W = $clog2(NB),
    localparam int SHW   = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_load,
    input  logic [1:0]       req_size,
    input  logic [XLEN-1:0]  req_base,
    input  logic             req_base_pc,
    input  logic             req_imm_sel,
    input  logic [XLEN-1:0]  req_imm,
    input  logic [XLEN-1:0]  req_oreg,
    input  logic [1:0]       req_sh_kind,
    input  logic [SHW-1:0]   req_sh_amt,
    input  logic             req_add,
    input  logic             req_pre,
    input  logic             req_wb,
    input  logic [REG_W-1:0] req_tgt,
    input  logic             req_unaligned_ok,
    input  logic [XLEN-1:0]  req_src,
    input  logic             ld_valid,
    input  logic [XLEN-1:0]  ld_word,
    output logic             acc_valid,
    output logic             acc_write,
    output logic [XLEN-1:0]  acc_addr,
    output logic [NB-1:0]    acc_be,
    output logic [XLEN-1:0]  acc_wdata,
    output logic             wb_valid,
    output logic [XLEN-1:0]  wb_value,
    output logic             flag_unpred,
    output logic             flag_unknown,
    output logic             res_valid,
    output logic [XLEN-1:0]  res_data,
    output logic             res_pc
);

    typedef struct packed {
        logic            acc_valid;
        logic            acc_write;
        logic [XLEN-1:0] acc_addr;
        logic [NB-1:0]   acc_be;
        logic [XLEN-1:0] acc_wdata;
        logic [1:0]      acc_size;
        logic            acc_ua;
        logic            acc_to_pc;
        logic            wb_valid;
        logic [XLEN-1:0] wb_value;
        logic            flag_unpred;
        logic            flag_unknown;
        logic            res_valid;
        logic [XLEN-1:0] res_data;
        logic            res_pc;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] off_addr_w;
    logic [XLEN-1:0] acc_addr_w;
    logic [NB-1:0]   be_w;
    logic [XLEN-1:0] wdata_w;
    logic [XLEN-1:0] ld_fmt_w;

    agu_offset #(.XLEN(XLEN)) u_offset (
        .base     (req_base),
        .base_pc  (req_base_pc),
        .imm_sel  (req_imm_sel),
        .imm      (req_imm),
        .oreg     (req_oreg),
        .sh_kind  (req_sh_kind),
        .sh_amt   (req_sh_amt),
        .add      (req_add),
        .pre      (req_pre),
        .off_addr (off_addr_w),
        .acc_addr (acc_addr_w)
    );

    agu_lanes #(.XLEN(XLEN)) u_lanes (
        .lo    (acc_addr_w[LOW_W-1:0]),
        .size  (req_size),
        .src   (req_src),
        .be    (be_w),
        .wdata (wdata_w)
    );

    // load shaping uses the access held from the previous request
    agu_ldfmt #(.XLEN(XLEN)) u_ldfmt (
        .word         (ld_word),
        .lo           (st_q.acc_addr[LOW_W-1:0]),
        .size         (st_q.acc_size),
        .unaligned_ok (st_q.acc_ua),
        .data         (ld_fmt_w)
    );

    always_comb begin
        logic misal;
        logic to_pc;
        st_d           = st_q;
        st_d.acc_valid = 1'b0;
        st_d.res_valid = 1'b0;
        misal = (acc_addr_w[LOW_W-1:0] != '0);
        to_pc = req_load && (acc_size_e'(req_size) == SZ_WORD)
                && (req_tgt == REG_W'(PC_IDX));
        if (req_valid) begin
            st_d.acc_valid    = 1'b1;
            st_d.acc_write    = !req_load;
            st_d.acc_addr     = acc_addr_w;
            st_d.acc_be       = be_w;
            st_d.acc_wdata    = wdata_w;
            st_d.acc_size     = req_size;
            st_d.acc_ua       = req_unaligned_ok;
            st_d.acc_to_pc    = to_pc;
            st_d.wb_valid     = req_wb;
            st_d.wb_value     = off_addr_w;
            st_d.flag_unpred  = to_pc && misal;
            st_d.flag_unknown = (acc_size_e'(req_size) == SZ_HALF)
                                && acc_addr_w[0] && !req_unaligned_ok;
        end
        if (ld_valid) begin
            st_d.res_valid = 1'b1;
            st_d.res_data  = ld_fmt_w;
            st_d.res_pc    = st_q.acc_to_pc && !st_q.flag_unpred;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_valid    = st_q.acc_valid;
    assign acc_write    = st_q.acc_write;
    assign acc_addr     = st_q.acc_addr;
    assign acc_be       = st_q.acc_be;
    assign acc_wdata    = st_q.acc_wdata;
    assign wb_valid     = st_q.wb_valid;
    assign wb_value     = st_q.wb_value;
    assign flag_unpred  = st_q.flag_unpred;
    assign flag_unknown = st_q.flag_unknown;
    assign res_valid    = st_q.res_valid;
    assign res_data     = st_q.res_data;
    assign res_pc       = st_q.res_pc;

    // R2: a post-indexed access leaves the base untouched
    a_r2_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_pre && !req_base_pc |=> acc_addr == $past(req_base));

    // R4: a program-counter base with post-indexing gives a word-aligned address
    a_r4_pc_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_base_pc && !req_pre |=> acc_addr[1:0] == 2'b00);

    // R3: pre-indexed writeback matches the access address
    a_r3_wb_pre_matches: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_pre && req_wb |=> wb_valid && wb_value == acc_addr);

    // R6: a byte access enables exactly one lane
    a_r6_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_size_e'(req_size) == SZ_BYTE |=> $countones(acc_be) == 1);

    // R8: byte loads are zero-extended
    a_r8_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && acc_size_e'(st_q.acc_size) == SZ_BYTE |=> res_data[XLEN-1:8] == '0);

    // R10: an unpredictable access never loads the program counter
    a_r10_unpred_no_pc: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && flag_unpred |=> !res_pc);

    // R12: the access strobe appears only after a request
    a_r12_acc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !acc_valid);

    // R11: the unknown flag is only raised for halfwords
    a_r11_unknown_half: assert property (@(posedge clk) disable iff (!rst_n)
        flag_unknown |-> acc_size_e'(st_q.acc_size) == SZ_HALF);

endmodule

// File: tb/test_ls_addr_unit.sv
`timescale 1ns/1ps
module test_ls_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_load = 0, req_base_pc = 0, req_imm_sel = 0;
    logic [1:0]  req_size = 0, req_sh_kind = 0;
    logic [31:0] req_base = 0, req_imm = 0, req_oreg = 0, req_src = 0, ld_word = 0;
    logic [4:0]  req_sh_amt = 0;
    logic        req_add = 0, req_pre = 0, req_wb = 0, req_unaligned_ok = 0, ld_valid = 0;
    logic [3:0]  req_tgt = 0;
    logic        acc_valid, acc_write, wb_valid, flag_unpred, flag_unknown, res_valid, res_pc;
    logic [31:0] acc_addr, acc_wdata, wb_value, res_data;
    logic [3:0]  acc_be;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ls_addr_unit i_ls_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
        .req_size(req_size), .req_base(req_base), .req_base_pc(req_base_pc),
        .req_imm_sel(req_imm_sel), .req_imm(req_imm), .req_oreg(req_oreg),
        .req_sh_kind(req_sh_kind), .req_sh_amt(req_sh_amt), .req_add(req_add),
        .req_pre(req_pre), .req_wb(req_wb), .req_tgt(req_tgt),
        .req_unaligned_ok(req_unaligned_ok), .req_src(req_src),
        .ld_valid(ld_valid), .ld_word(ld_word), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .wb_valid(wb_valid), .wb_value(wb_value),
        .flag_unpred(flag_unpred), .flag_unknown(flag_unknown),
        .res_valid(res_valid), .res_data(res_data), .res_pc(res_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one request with an immediate offset; outputs checked after the edge
    task automatic issue_imm(input logic ld, input logic [1:0] sz, input logic [31:0] base,
                             input logic bpc, input logic [31:0] imm, input logic add,
                             input logic pre, input logic wb, input logic [3:0] tgt,
                             input logic ua, input logic [31:0] src);
        req_load = ld; req_size = sz; req_base = base; req_base_pc = bpc;
        req_imm_sel = 1; req_imm = imm; req_add = add; req_pre = pre; req_wb = wb;
        req_tgt = tgt; req_unaligned_ok = ua; req_src = src; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic return_word(input logic [31:0] w);
        ld_word = w; ld_valid = 1;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic t_reset;
        chk("R12 reset acc_valid", {31'd0, acc_valid}, 0);
        chk("R12 reset acc_addr", acc_addr, 0);
        chk("R12 reset wb_valid", {31'd0, wb_valid}, 0);
        chk("R12 reset res_valid", {31'd0, res_valid}, 0);
    endtask

    task automatic t_pre_add;
        issue_imm(0, 2, 32'h0000_1000, 0, 32'h24, 1, 1, 1, 4'd2, 0, 32'hCAFE_F00D);
        chk("R1 pre add addr", acc_addr, 32'h0000_1024);
        chk("R3 pre wb value", wb_value, 32'h0000_1024);
        chk("R3 wb_valid", {31'd0, wb_valid}, 1);
        chk("R6 word be", {28'd0, acc_be}, 32'hF);
        chk("R7 word wdata", acc_wdata, 32'hCAFE_F00D);
        chk("R7 write", {31'd0, acc_write}, 1);
        chk("R12 acc pulse high", {31'd0, acc_valid}, 1);
        @(negedge clk);
        chk("R12 acc pulse low", {31'd0, acc_valid}, 0);
        chk("R12 addr held", acc_addr, 32'h0000_1024);
    endtask

    task automatic t_post_sub;
        issue_imm(0, 2, 32'h0000_2000, 0, 32'h8, 0, 0, 1, 4'd1, 0, 0);
        chk("R2 post addr is base", acc_addr, 32'h0000_2000);
        chk("R1 sub offset wb", wb_value, 32'h0000_1FF8);
        issue_imm(0, 2, 32'h0000_2000, 0, 32'h8, 0, 1, 0, 4'd1, 0, 0);
        chk("R1 pre sub addr", acc_addr, 32'h0000_1FF8);
        chk("R3 no writeback", {31'd0, wb_valid}, 0);
    endtask

    task automatic t_shifts;
        logic [31:0] exp_a [5];
        exp_a[0] = 32'h0000_F110; exp_a[1] = 32'h0800_01F0;
        exp_a[2] = 32'hF800_01F0; exp_a[3] = 32'h1800_01F0;
        exp_a[4] = 32'h8000_1001;
        for (int k = 0; k < 5; k++) begin
            req_load = 0; req_size = 2; req_base = 32'h100; req_base_pc = 0;
            req_imm_sel = 0; req_oreg = 32'h8000_0F01;
            req_sh_kind = (k == 4) ? 2'd1 : 2'(k);
            req_sh_amt = (k == 4) ? 5'd0 : 5'd4;
            req_add = 1; req_pre = 1; req_wb = 0; req_tgt = 0; req_valid = 1;
            @(posedge clk);
            @(negedge clk);
            req_valid = 0;
            chk($sformatf("R5 shift case %0d", k), acc_addr, exp_a[k]);
        end
    endtask

    task automatic t_pc_base;
        issue_imm(1, 2, 32'h0000_8007, 1, 32'h3, 1, 1, 0, 4'd3, 0, 0);
        chk("R4 pc base pre", acc_addr, 32'h0000_8007);
        issue_imm(1, 2, 32'h0000_8007, 1, 32'h3, 1, 0, 1, 4'd3, 0, 0);
        chk("R4 pc base post", acc_addr, 32'h0000_8004);
        chk("R4 pc base wb", wb_value, 32'h0000_8007);
    endtask

    task automatic t_byte;
        issue_imm(0, 0, 32'h0000_0300, 0, 32'h3, 1, 1, 0, 4'd4, 0, 32'h1234_56A5);
        chk("R6 byte be lane3", {28'd0, acc_be}, 32'h8);
        chk("R7 byte wdata", acc_wdata, 32'hA5A5_A5A5);
        issue_imm(1, 0, 32'h0000_0302, 0, 32'h0, 1, 1, 0, 4'd4, 0, 0);
        chk("R6 byte be lane2", {28'd0, acc_be}, 32'h4);
        chk("R7 load not write", {31'd0, acc_write}, 0);
        return_word(32'hAABB_CCDD);
        chk("R8 byte load lane2", res_data, 32'h0000_00BB);
        chk("R12 res pulse", {31'd0, res_valid}, 1);
        @(negedge clk);
        chk("R12 res pulse low", {31'd0, res_valid}, 0);
    endtask

    task automatic t_half;
        issue_imm(1, 1, 32'h0000_0402, 0, 32'h0, 1, 1, 0, 4'd5, 0, 0);
        chk("R6 half be upper", {28'd0, acc_be}, 32'hC);
        chk("R11 aligned half no flag", {31'd0, flag_unknown}, 0);
        return_word(32'hAABB_CCDD);
        chk("R8 half load upper", res_data, 32'h0000_AABB);
        issue_imm(0, 1, 32'h0000_0401, 0, 32'h0, 1, 1, 0, 4'd5, 0, 32'h0000_BEEF);
        chk("R6 half be lower", {28'd0, acc_be}, 32'h3);
        chk("R7 half wdata", acc_wdata, 32'hBEEF_BEEF);
        chk("R11 odd half flag", {31'd0, flag_unknown}, 1);
        issue_imm(0, 1, 32'h0000_0401, 0, 32'h0, 1, 1, 0, 4'd5, 1, 32'h0000_BEEF);
        chk("R11 odd half with support", {31'd0, flag_unknown}, 0);
        issue_imm(0, 2, 32'h0000_0401, 0, 32'h0, 1, 1, 0, 4'd5, 0, 0);
        chk("R11 word never unknown", {31'd0, flag_unknown}, 0);
    endtask

    task automatic t_word_rot;
        issue_imm(1, 2, 32'h0000_0501, 0, 32'h0, 1, 1, 0, 4'd6, 0, 0);
        return_word(32'h1122_3344);
        chk("R9 rotate by 8", res_data, 32'h4411_2233);
        issue_imm(1, 2, 32'h0000_0503, 0, 32'h0, 1, 1, 0, 4'd6, 0, 0);
        return_word(32'h1122_3344);
        chk("R9 rotate by 24", res_data, 32'h2233_4411);
        issue_imm(1, 2, 32'h0000_0501, 0, 32'h0, 1, 1, 0, 4'd6, 1, 0);
        return_word(32'h1122_3344);
        chk("R9 unaligned supported", res_data, 32'h1122_3344);
        issue_imm(1, 2, 32'h0000_0500, 0, 32'h0, 1, 1, 0, 4'd6, 0, 0);
        return_word(32'h1122_3344);
        chk("R9 aligned unchanged", res_data, 32'h1122_3344);
        chk("R10 non-pc target", {31'd0, res_pc}, 0);
    endtask

    task automatic t_pc_load;
        issue_imm(1, 2, 32'h0000_0600, 0, 32'h4, 1, 1, 0, 4'd15, 0, 0);
        chk("R10 aligned no unpred", {31'd0, flag_unpred}, 0);
        return_word(32'h0000_1234);
        chk("R10 pc load marked", {31'd0, res_pc}, 1);
        chk("R10 pc load data", res_data, 32'h0000_1234);
        issue_imm(1, 2, 32'h0000_0602, 0, 32'h0, 1, 1, 0, 4'd15, 0, 0);
        chk("R10 misaligned unpred", {31'd0, flag_unpred}, 1);
        return_word(32'h0000_1234);
        chk("R10 misaligned no pc", {31'd0, res_pc}, 0);
        issue_imm(1, 0, 32'h0000_0602, 0, 32'h0, 1, 1, 0, 4'd15, 0, 0);
        chk("R10 byte to 15 no unpred", {31'd0, flag_unpred}, 0);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pre_add();
        t_post_sub();
        t_shifts();
        t_pc_base();
        t_byte();
        t_half();
        t_word_rot();
        t_pc_load();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule